// File: doc/BRIEF.md
# Interrupt Priority Level Resolver

This block decides each clock whether a pending interrupt outranks the processor's current priority. It looks at two request vectors in parallel. Software requests sit in a fixed contiguous bit window, and each set bit there is worth its offset into the window plus one. External request lines sit in a higher window, and each set bit there is worth its own bit index. From these it forms a single winning level and a summary word that carries every pending bit at its own position.

The winning level is compared against a 5-bit priority register held inside the block. When the level is nonzero and strictly above that register, the block raises a registered one-cycle take pulse. On the same edge it captures the summary word and the winning level into status registers. After a take, no further evaluation happens until the consumer returns an acknowledge, so one request cannot be taken twice. Vectoring and handler dispatch are left to the consumer of the take pulse.

Top module: `ipl_resolver`

## Requirements
- R1: A set software request bit at index i, for 4 <= i <= 18, gives level i - 3. Indices 4 to 18 therefore give levels 1 to 15.
- R2: A set external request bit at index i, for 16 <= i <= 31, gives level i.
- R3: The winner is the last pending bit in an ascending scan of the software window followed by the external window. Any pending external line therefore beats every software request, and within a window the highest index wins.
- R4: The summary word is the OR of every pending in-window software bit and every pending in-window external bit, each at its own bit position.
- R5: A take happens only when the winning level is nonzero and strictly greater than the priority register. An equal level does not cause a take.
- R6: When the condition holds at a clock edge, take is high for the following cycle. On that same edge the summary register loads the summary word and the ID register loads the winning level. At all other edges both status registers hold their values.
- R7: After a take, no further take occurs until ack is sampled high at an edge. The cycle after a take never shows take high.
- R8: When ipl_wr_en is high at an edge, the priority register loads ipl_wr_data, and from the next cycle on the comparison uses the new value.
- R9: Software bits outside 18..4 and external bits below 16 are ignored. They affect neither the level nor the summary.
- R10: Synchronous reset clears take, the summary register, the ID register, the priority register and the acknowledge wait. While every in-window request is zero, take stays low.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_req | input | 32 | Software request bits (window 18..4) |
| ext_req | input | 32 | External request lines (window 31..16) |
| ipl_wr_en | input | 1 | Priority register write strobe |
| ipl_wr_data | input | 5 | New priority level |
| ack | input | 1 | Consumer acknowledge; re-enables evaluation |
| take | output | 1 | One-cycle interrupt-take pulse |
| isr_q | output | 32 | Captured summary word |
| intid_q | output | 5 | Captured winning level |
| ipl_q | output | 5 | Current priority register |

## Verification
Single software bits at both ends of the window check the offset mapping and its boundaries. Software and external bits mixed together check the ascending last-wins rule and the merged summary. A level equal to the priority register is separated from one just above it, which shows the strict comparison. Out-of-window bits alone confirm they are ignored, and holding a request without an acknowledge shows that it is taken only once. A long run of random requests, acknowledges and priority writes is then compared each cycle against a behavioural model.

// File: rtl/ipl_pkg.sv
package ipl_pkg;
  localparam int IPL_REQ_W  = 32;
  localparam int IPL_LVL_W  = 5;
  localparam int IPL_SW_LO  = 4;
  localparam int IPL_SW_HI  = 18;
  localparam int IPL_EXT_LO = 16;
  localparam int IPL_EXT_HI = 31;

  typedef enum logic {
    ARB_OPEN = 1'b0,
    ARB_WAIT = 1'b1
  } arb_state_e;
endpackage

// File: rtl/ipl_src_scan.sv
// Ascending scan of one request window; the last set bit sets the level.
module ipl_src_scan #(
  parameter int REQ_W = 32,
  parameter int LO    = 4,
  parameter int HI    = 18,
  parameter int LVL_W = 5,
  parameter int BIAS  = 1
) (
  input  logic [REQ_W-1:0] req,
  output logic [LVL_W-1:0] lvl,
  output logic [REQ_W-1:0] hits
);
  always_comb begin
    lvl  = '0;
    hits = '0;
    for (int i = 0; i < REQ_W; i++) begin
      if (req[i] && i >= LO && i <= HI) begin
        lvl     = LVL_W'(i - LO + BIAS);
        hits[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ipl_combine.sv
// Merge two windows: the later window wins when it has anything pending.
module ipl_combine #(
  parameter int REQ_W = 32,
  parameter int LVL_W = 5
) (
  input  logic [LVL_W-1:0] early_lvl,
  input  logic [REQ_W-1:0] early_hits,
  input  logic [LVL_W-1:0] late_lvl,
  input  logic [REQ_W-1:0] late_hits,
  output logic [LVL_W-1:0] win_lvl,
  output logic [REQ_W-1:0] summary
);
  always_comb begin
    win_lvl = (late_lvl != '0) ? late_lvl : early_lvl;
    summary = early_hits | late_hits;
  end
endmodule

// File: rtl/ipl_take_ctl.sv
module ipl_take_ctl
  import ipl_pkg::*;
#(
  parameter int REQ_W = 32,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] win_lvl,
  input  logic [REQ_W-1:0] summary,
  input  logic [LVL_W-1:0] cur_ipl,
  input  logic             ack,
  output logic             take,
  output logic [REQ_W-1:0] isr_q,
  output logic [LVL_W-1:0] intid_q
);
  arb_state_e state;
  logic       fire;

  assign fire = (state == ARB_OPEN) && (win_lvl != '0) && (win_lvl > cur_ipl);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ARB_OPEN;
      take    <= 1'b0;
      isr_q   <= '0;
      intid_q <= '0;
    end else begin
      take <= fire;
      if (fire) begin
        state   <= ARB_WAIT;
        isr_q   <= summary;
        intid_q <= win_lvl;
      end else if (ack) begin
        state <= ARB_OPEN;
      end
    end
  end
endmodule

// File: rtl/ipl_resolver.sv
module ipl_resolver
  import ipl_pkg::*;
#(
  parameter int REQ_W  = IPL_REQ_W,
  parameter int LVL_W  = IPL_LVL_W,
  parameter int SW_LO  = IPL_SW_LO,
  parameter int SW_HI  = IPL_SW_HI,
  parameter int EXT_LO = IPL_EXT_LO,
  parameter int EXT_HI = IPL_EXT_HI
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REQ_W-1:0] sw_req,
  input  logic [REQ_W-1:0] ext_req,
  input  logic             ipl_wr_en,
  input  logic [LVL_W-1:0] ipl_wr_data,
  input  logic             ack,
  output logic             take,
  output logic [REQ_W-1:0] isr_q,
  output logic [LVL_W-1:0] intid_q,
  output logic [LVL_W-1:0] ipl_q
);
  localparam int SW_BIAS  = 1;
  localparam int EXT_BIAS = EXT_LO;

  logic [LVL_W-1:0] sw_lvl, ext_lvl, win_lvl;
  logic [REQ_W-1:0] sw_hits, ext_hits, summary;

  ipl_src_scan #(.REQ_W(REQ_W), .LO(SW_LO), .HI(SW_HI), .LVL_W(LVL_W), .BIAS(SW_BIAS))
    u_sw_scan (.req(sw_req), .lvl(sw_lvl), .hits(sw_hits));

  ipl_src_scan #(.REQ_W(REQ_W), .LO(EXT_LO), .HI(EXT_HI), .LVL_W(LVL_W), .BIAS(EXT_BIAS))
    u_ext_scan (.req(ext_req), .lvl(ext_lvl), .hits(ext_hits));

  ipl_combine #(.REQ_W(REQ_W), .LVL_W(LVL_W)) u_combine (
    .early_lvl(sw_lvl), .early_hits(sw_hits),
    .late_lvl(ext_lvl), .late_hits(ext_hits),
    .win_lvl(win_lvl), .summary(summary)
  );

  always_ff @(posedge clk) begin
    if (rst)            ipl_q <= '0;
    else if (ipl_wr_en) ipl_q <= ipl_wr_data;
  end

  ipl_take_ctl #(.REQ_W(REQ_W), .LVL_W(LVL_W)) u_take_ctl (
    .clk(clk), .rst(rst), .win_lvl(win_lvl), .summary(summary),
    .cur_ipl(ipl_q), .ack(ack), .take(take), .isr_q(isr_q), .intid_q(intid_q)
  );
endmodule

// File: rtl/ipl_resolver_chk.sv
module ipl_resolver_chk #(
  parameter int REQ_W  = 32,
  parameter int LVL_W  = 5,
  parameter int SW_LO  = 4,
  parameter int SW_HI  = 18,
  parameter int EXT_LO = 16,
  parameter int EXT_HI = 31
) (
  input logic             clk,
  input logic             rst,
  input logic [REQ_W-1:0] sw_req,
  input logic [REQ_W-1:0] ext_req,
  input logic             ipl_wr_en,
  input logic [LVL_W-1:0] ipl_wr_data,
  input logic             take,
  input logic [REQ_W-1:0] isr_q,
  input logic [LVL_W-1:0] intid_q,
  input logic [LVL_W-1:0] ipl_q
);
  AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    take |=> !take);                                              // R7
  AST_TAKE_ABOVE_IPL: assert property (@(posedge clk) disable iff (rst)
    take |-> (intid_q > $past(ipl_q)));                           // R5
  AST_TAKE_NONZERO: assert property (@(posedge clk) disable iff (rst)
    take |-> (intid_q != '0));                                    // R5
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !take |-> ($stable(isr_q) && $stable(intid_q)));              // R6
  AST_IPL_LOAD: assert property (@(posedge clk) disable iff (rst)
    ipl_wr_en |=> (ipl_q == $past(ipl_wr_data)));                 // R8
  AST_IDLE_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
    (sw_req[SW_HI:SW_LO] == '0 && ext_req[EXT_HI:EXT_LO] == '0) |=> !take); // R10
endmodule

bind ipl_resolver ipl_resolver_chk #(
  .REQ_W(REQ_W), .LVL_W(LVL_W), .SW_LO(SW_LO), .SW_HI(SW_HI),
  .EXT_LO(EXT_LO), .EXT_HI(EXT_HI)
) u_chk (
  .clk(clk), .rst(rst), .sw_req(sw_req), .ext_req(ext_req),
  .ipl_wr_en(ipl_wr_en), .ipl_wr_data(ipl_wr_data), .take(take),
  .isr_q(isr_q), .intid_q(intid_q), .ipl_q(ipl_q)
);

// File: tb/tb_ipl_resolver.sv
`timescale 1ns/1ps
module tb_ipl_resolver;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] sw_req = '0, ext_req = '0;
  logic        ipl_wr_en = 1'b0;
  logic [4:0]  ipl_wr_data = '0;
  logic        ack = 1'b0;
  logic        take;
  logic [31:0] isr_q;
  logic [4:0]  intid_q, ipl_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ipl_resolver dut (
    .clk(clk), .rst(rst), .sw_req(sw_req), .ext_req(ext_req),
    .ipl_wr_en(ipl_wr_en), .ipl_wr_data(ipl_wr_data), .ack(ack),
    .take(take), .isr_q(isr_q), .intid_q(intid_q), .ipl_q(ipl_q)
  );

  // Behavioural reference model
  logic        m_take = 1'b0, m_busy = 1'b0;
  logic [31:0] m_isr = '0;
  int          m_id = 0, m_ipl = 0;

  always @(posedge clk) begin
    int          lvl;
    logic [31:0] sum;
    if (rst) begin
      m_take = 1'b0; m_busy = 1'b0; m_isr = '0; m_id = 0; m_ipl = 0;
    end else begin
      lvl = 0; sum = '0;
      for (int i = 4; i <= 18; i++)
        if (sw_req[i]) begin lvl = i - 3; sum[i] = 1'b1; end
      for (int i = 16; i <= 31; i++)
        if (ext_req[i]) begin lvl = i; sum[i] = 1'b1; end
      m_take = 1'b0;
      if (!m_busy && lvl != 0 && lvl > m_ipl) begin
        m_take = 1'b1; m_busy = 1'b1; m_isr = sum; m_id = lvl;
      end else if (ack) begin
        m_busy = 1'b0;
      end
      if (ipl_wr_en) m_ipl = int'(ipl_wr_data);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(take == m_take, "R5 R7 take vs model", 32'(take), 32'(m_take));
      chk(isr_q == m_isr, "R4 R6 summary vs model", isr_q, m_isr);
      chk(int'(intid_q) == m_id, "R3 R6 id vs model", 32'(intid_q), 32'(m_id));
      chk(int'(ipl_q) == m_ipl, "R8 priority vs model", 32'(ipl_q), 32'(m_ipl));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic ack_pulse();
    ack = 1'b1; tick(1); ack = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(3);
    rst = 1'b0;
    // R10: reset state
    chk(take == 1'b0, "R10 take after reset", 32'(take), 0);
    chk(isr_q == '0, "R10 summary after reset", isr_q, 0);
    chk(intid_q == '0 && ipl_q == '0, "R10 id/priority after reset", {intid_q, ipl_q}, 0);
    tick(2);
    chk(take == 1'b0, "R10 no take while idle", 32'(take), 0);

    // R1 lowest software bit
    sw_req = 32'h10; tick(1);
    chk(take == 1'b1, "R1 take on bit 4", 32'(take), 1);
    chk(intid_q == 5'd1, "R1 level of bit 4", 32'(intid_q), 1);
    chk(isr_q == 32'h10, "R6 summary of bit 4", isr_q, 32'h10);
    tick(1);
    chk(take == 1'b0, "R7 pulse is one cycle", 32'(take), 0);
    tick(3);
    chk(take == 1'b0, "R7 held request not retaken", 32'(take), 0);
    sw_req = '0; ack_pulse(); tick(1);

    // R1 R3 R4 top of software window with a lower bit
    sw_req = 32'h0004_0020; tick(1);
    chk(intid_q == 5'd15, "R1 R3 level of bit 18", 32'(intid_q), 15);
    chk(isr_q == 32'h0004_0020, "R4 merged summary", isr_q, 32'h0004_0020);
    sw_req = '0; ack_pulse(); tick(1);

    // R2 R3 external beats software
    sw_req = 32'h400; ext_req = 32'h0010_0000; tick(1);
    chk(intid_q == 5'd20, "R2 R3 external wins", 32'(intid_q), 20);
    chk(isr_q == 32'h0010_0400, "R4 summary of both", isr_q, 32'h0010_0400);
    sw_req = '0; ext_req = '0; ack_pulse();

    // R5 R8 equal level is not taken, one above is
    ipl_wr_en = 1'b1; ipl_wr_data = 5'd20; tick(1); ipl_wr_en = 1'b0;
    chk(ipl_q == 5'd20, "R8 priority write", 32'(ipl_q), 20);
    ext_req = 32'h0010_0000; tick(2);
    chk(take == 1'b0 && intid_q == 5'd20, "R5 equal level ignored", 32'(take), 0);
    ext_req = 32'h0020_0000; tick(1);
    chk(take == 1'b1 && intid_q == 5'd21, "R5 higher level taken", 32'(intid_q), 21);
    ext_req = '0; ack_pulse();
    ipl_wr_en = 1'b1; ipl_wr_data = 5'd0; tick(1); ipl_wr_en = 1'b0;

    // R9 out-of-window bits only
    sw_req = 32'hFFF8_000F; ext_req = 32'h0000_FFFF; tick(3);
    chk(take == 1'b0, "R9 out-of-window ignored", 32'(take), 0);
    chk(isr_q == 32'h0020_0000, "R9 summary untouched", isr_q, 32'h0020_0000);
    sw_req = '0; ext_req = '0; tick(1);

    // Random traffic against the model
    for (int k = 0; k < 600; k++) begin
      sw_req  = ($urandom_range(0, 3) == 0) ? $urandom() : '0;
      ext_req = ($urandom_range(0, 4) == 0) ? ($urandom() & 32'hFFF0_0000) >> $urandom_range(0, 12) : '0;
      ack = ($urandom_range(0, 2) == 0);
      ipl_wr_en = ($urandom_range(0, 7) == 0);
      ipl_wr_data = 5'($urandom());
      tick(1);
    end
    ack = 1'b0; ipl_wr_en = 1'b0; sw_req = '0; ext_req = '0;
    tick(2);
    finish_run();
  end
endmodule